// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Wake-up

This block receives asynchronous serial characters on a single line. It uses an external strobe that pulses sixteen times per bit period. A high-to-low transition on the idle line marks a possible start bit. The start bit is confirmed at mid-bit. The receiver then collects 8 data bits, or 9 in wake-up mode, least significant bit first. An optional parity bit and a stop period of one, one and a half, or two bit times follow. Each bit value is a majority vote of three consecutive oversamples.

When the programmed stop period ends, the assembled character moves into a holding buffer. In the same cycle the buffer-full flag is set and the parity, framing and overrun flags are refreshed. A one-cycle load pulse marks that transfer. Host logic reads the character and clears the full flag with a read strobe.

Wake-up mode supports multi-drop links. A character whose ninth bit is 0 is discarded without any visible effect, so a sleeping node only sees address characters. Disabling the receiver does not cut off a character in flight: that character is finished, and only later start bits are ignored.

Top module: `uart_rx_core`

## Requirements
- R1: With the receiver enabled and idle, a falling edge on `rxd` begins a frame. If the vote of oversamples 7, 8 and 9 of the start bit is 1, the frame is abandoned, nothing is loaded and the receiver goes idle.
- R2: Data bits are taken least significant first, each bit being the majority of oversamples 7, 8 and 9 of its bit time. In 8-bit mode `rx_data[8]` reads 0.
- R3: `par_mode` selects 00 none, 01 even, 10 odd, 11 none. With parity on, one parity bit follows the data. `err_parity` is set when the count of ones over the data bits plus the parity bit is odd (even mode) or even (odd mode).
- R4: `stop_mode` selects 00 one, 01 one and a half, 10 or 11 two stop bits. For one stop bit or the first of two, the vote uses oversamples 7 to 9 of the stop period. For the second of two, it uses samples 23 to 25. For one and a half, it uses samples 15 to 17. `err_frame` is set when any such vote is 0.
- R5: At the end of the last stop period, in a single cycle, the character enters `rx_data`, `rx_full` goes to 1, `rx_load` pulses for one cycle, and the parity and framing flags are rewritten. This happens whether or not the stop bits were valid. After reset the buffer is empty and all flags are 0.
- R6: `err_overrun` is set by a transfer that occurs while `rx_full` is still 1 and no read is given in that cycle. Otherwise a transfer clears it.
- R7: A `rd_buf` pulse clears `rx_full` from the next cycle on. The error flags keep their values until the next transfer.
- R8: With `wake_mode` at 1, frames carry 9 data bits and `rx_data[8]` holds the ninth. A frame whose ninth bit is 0 changes neither the buffer, the full flag, the error flags, nor `rx_load`.
- R9: Clearing `rx_en` lets a frame already in progress complete with its flags. Falling edges that arrive while `rx_en` is 0 and the receiver is idle start nothing.
- R10: After a frame, a new frame starts only on a fresh falling edge. A line that is still low when the stop period ends does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling strobe, 16 pulses per bit time |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receiver enable |
| par_mode | input | 2 | Parity select (00 none, 01 even, 10 odd, 11 none) |
| stop_mode | input | 2 | Stop period select (00 one, 01 one and a half, 1x two) |
| wake_mode | input | 1 | 9-bit frames, ninth bit 0 discarded |
| rd_buf | input | 1 | Buffer read strobe, clears full flag |
| rx_data | output | DATA_W+1 | Holding buffer; top bit is ninth bit in wake-up mode |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_load | output | 1 | One-cycle pulse on each transfer into the buffer |
| err_parity | output | 1 | Parity mismatch on last transferred frame |
| err_frame | output | 1 | A stop vote was 0 on last transferred frame |
| err_overrun | output | 1 | Last transfer overwrote an unread character |

## Verification
The hardest conditions to reach are those that depend on where the three oversamples fall inside a stop period longer than one bit. A line that is high at samples 7 to 9 but low at 15 to 17 must yield a framing error only in one-and-a-half mode. A second stop bit that is low must be caught at samples 23 to 25. The stimulus drives the stop period one oversample tick at a time from a bit pattern, so the line can fall partway through it. The bench also leaves the line low beyond the end of the stop period, to show that no frame starts without a fresh edge. It clears the enable a few bits into a frame to show that the frame still completes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // oversampling ratio fixed by the line protocol
    localparam int OSR       = 16;
    localparam int PH_W      = $clog2(2 * OSR);
    localparam int MID_PH    = OSR / 2;          // tick of the 9th sample
    localparam int HALF_PH   = OSR;              // tick of the 17th sample
    localparam int SECOND_PH = OSR + OSR / 2;    // tick of the 25th sample
    localparam int END_PH    = OSR - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_ONE_HALF = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_TWO_ALT  = 2'b11
    } stop_mode_e;

    typedef struct packed {
        logic       wake;
        par_mode_e  par;
        stop_mode_e stop;
    } rx_cfg_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic par_enabled(input par_mode_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic two_stops(input stop_mode_e s);
        return (s == STOP_TWO) || (s == STOP_TWO_ALT);
    endfunction

    function automatic logic [PH_W-1:0] stop_last_phase(input stop_mode_e s);
        case (s)
            STOP_ONE:      return PH_W'(OSR - 1);
            STOP_ONE_HALF: return PH_W'(OSR + OSR / 2 - 1);
            default:       return PH_W'(2 * OSR - 1);
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd_i,
    output logic rxd_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], rxd_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rxd_o  = sync_q[STAGES-1];
    assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
    import uart_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_i,
    input  logic            clear_i,
    input  logic            rxd_i,
    output logic [PH_W-1:0] phase_o,
    output logic            vote_o
);
    logic [PH_W-1:0] phase_q;
    logic [1:0]      hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            hist_q  <= 2'b11;
        end else if (clear_i) begin
            phase_q <= '0;
            hist_q  <= 2'b11;
        end else if (tick_i) begin
            phase_q <= phase_q + 1'b1;
            hist_q  <= {hist_q[0], rxd_i};
        end
    end

    // two stored samples plus the one being taken on this tick
    assign vote_o  = maj3(hist_q[1], hist_q[0], rxd_i);
    assign phase_o = phase_q;

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  rx_cfg_t         cfg_i,
    input  logic            fall_i,
    input  logic            tick_i,
    input  logic [PH_W-1:0] phase_i,
    input  logic            vote_i,
    output logic            clear_o,
    output logic            done_o,
    output logic [DATA_W:0] data_o,
    output logic            perr_o,
    output logic            ferr_o,
    output logic            wake_o
);
    localparam int NB_W = $clog2(DATA_W + 1);

    rx_state_e        state_q;
    rx_cfg_t          cfg_q;
    logic [NB_W-1:0]  bit_q;
    logic [DATA_W:0]  shreg_q;
    logic             parbit_q;
    logic             ferr_q;
    logic             done_q;

    logic            at_mid, at_end, stop_vote;
    logic [NB_W-1:0] last_bit;

    assign at_mid   = tick_i && (phase_i == PH_W'(MID_PH));
    assign at_end   = tick_i && (phase_i == PH_W'(END_PH));
    assign last_bit = cfg_q.wake ? NB_W'(DATA_W) : NB_W'(DATA_W - 1);

    always_comb begin
        stop_vote = 1'b0;
        if (tick_i) begin
            if (cfg_q.stop == STOP_ONE_HALF)
                stop_vote = (phase_i == PH_W'(HALF_PH));
            else
                stop_vote = (phase_i == PH_W'(MID_PH)) ||
                            (two_stops(cfg_q.stop) && phase_i == PH_W'(SECOND_PH));
        end
    end

    assign clear_o = ((state_q == ST_IDLE) && en_i && fall_i) ||
                     ((state_q == ST_START || state_q == ST_DATA || state_q == ST_PAR) && at_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cfg_q    <= '0;
            bit_q    <= '0;
            shreg_q  <= '0;
            parbit_q <= 1'b0;
            ferr_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (en_i && fall_i) begin
                        state_q <= ST_START;
                        cfg_q   <= cfg_i;
                    end
                end
                ST_START: begin
                    if (at_mid && vote_i) begin
                        state_q <= ST_IDLE;
                    end else if (at_end) begin
                        state_q <= ST_DATA;
                        bit_q   <= '0;
                        shreg_q <= '0;
                    end
                end
                ST_DATA: begin
                    if (at_mid) shreg_q[bit_q] <= vote_i;
                    if (at_end) begin
                        if (bit_q == last_bit) begin
                            state_q <= par_enabled(cfg_q.par) ? ST_PAR : ST_STOP;
                            ferr_q  <= 1'b0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (at_mid) parbit_q <= vote_i;
                    if (at_end) begin
                        state_q <= ST_STOP;
                        ferr_q  <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (stop_vote && !vote_i) ferr_q <= 1'b1;
                    if (tick_i && phase_i == stop_last_phase(cfg_q.stop)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done_o = done_q;
    assign data_o = shreg_q;
    assign ferr_o = ferr_q;
    assign wake_o = cfg_q.wake;
    assign perr_o = par_enabled(cfg_q.par) &&
                    ((^shreg_q ^ parbit_q) != (cfg_q.par == PAR_ODD));

    assert_off_stays_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !en_i) |=> (state_q == ST_IDLE))
        else $error("idle receiver left idle while disabled");

    assert_glitch_abort_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && at_mid && vote_i) |=> (state_q == ST_IDLE && !done_q))
        else $error("false start not abandoned");

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q)
        else $error("completion lasted more than one cycle");

    assert_done_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(state_q) == ST_STOP && state_q == ST_IDLE))
        else $error("completion outside stop period");

endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            done_i,
    input  logic [DATA_W:0] data_i,
    input  logic            perr_i,
    input  logic            ferr_i,
    input  logic            wake_i,
    input  logic            rd_i,
    output logic [DATA_W:0] data_o,
    output logic            full_o,
    output logic            load_o,
    output logic            perr_o,
    output logic            ferr_o,
    output logic            oerr_o
);
    logic [DATA_W:0] data_q;
    logic            full_q, load_q, perr_q, ferr_q, oerr_q;
    logic            keep;

    assign keep = done_i && (!wake_i || data_i[DATA_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
            load_q <= 1'b0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            oerr_q <= 1'b0;
        end else begin
            load_q <= keep;
            if (keep) begin
                data_q <= data_i;
                full_q <= 1'b1;
                perr_q <= perr_i;
                ferr_q <= ferr_i;
                oerr_q <= full_q && !rd_i;
            end else if (rd_i) begin
                full_q <= 1'b0;
            end
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;
    assign load_o = load_q;
    assign perr_o = perr_q;
    assign ferr_o = ferr_q;
    assign oerr_o = oerr_q;

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !done_i) |=> !full_q)
        else $error("read strobe did not empty buffer");

    assert_flags_move_on_load_R5: assert property (@(posedge clk) disable iff (rst)
        !load_q |-> $stable({perr_q, ferr_q, oerr_q}))
        else $error("error flags changed without a transfer");

    assert_drop_wake_R8: assert property (@(posedge clk) disable iff (rst)
        (done_i && wake_i && !data_i[DATA_W]) |=> (!load_q && $stable(data_q) && $stable(full_q)))
        else $error("non-address frame reached buffer");

    assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (load_q && oerr_q) |-> $past(full_q && !rd_i))
        else $error("overrun without unread character");

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            os_tick,
    input  logic            rxd,
    input  logic            rx_en,
    input  logic [1:0]      par_mode,
    input  logic [1:0]      stop_mode,
    input  logic            wake_mode,
    input  logic            rd_buf,
    output logic [DATA_W:0] rx_data,
    output logic            rx_full,
    output logic            rx_load,
    output logic            err_parity,
    output logic            err_frame,
    output logic            err_overrun
);
    logic            line_s, line_fall;
    logic            samp_clear, samp_vote;
    logic [PH_W-1:0] samp_phase;
    logic            fr_done, fr_perr, fr_ferr, fr_wake;
    logic [DATA_W:0] fr_data;
    rx_cfg_t         cfg;

    assign cfg.wake = wake_mode;
    assign cfg.par  = par_mode_e'(par_mode);
    assign cfg.stop = stop_mode_e'(stop_mode);

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .rxd_i  (rxd),
        .rxd_o  (line_s),
        .fall_o (line_fall)
    );

    rx_bit_sampler u_samp (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (os_tick),
        .clear_i (samp_clear),
        .rxd_i   (line_s),
        .phase_o (samp_phase),
        .vote_o  (samp_vote)
    );

    rx_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en_i    (rx_en),
        .cfg_i   (cfg),
        .fall_i  (line_fall),
        .tick_i  (os_tick),
        .phase_i (samp_phase),
        .vote_i  (samp_vote),
        .clear_o (samp_clear),
        .done_o  (fr_done),
        .data_o  (fr_data),
        .perr_o  (fr_perr),
        .ferr_o  (fr_ferr),
        .wake_o  (fr_wake)
    );

    rx_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .done_i (fr_done),
        .data_i (fr_data),
        .perr_i (fr_perr),
        .ferr_i (fr_ferr),
        .wake_i (fr_wake),
        .rd_i   (rd_buf),
        .data_o (rx_data),
        .full_o (rx_full),
        .load_o (rx_load),
        .perr_o (err_parity),
        .ferr_o (err_frame),
        .oerr_o (err_overrun)
    );

endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int DW         = 8;
    localparam int BIT_T      = 16;

    logic          clk, rst, os_tick, rxd, rx_en, wake_mode, rd_buf;
    logic [1:0]    par_mode, stop_mode;
    logic [DW:0]   rx_data;
    logic          rx_full, rx_load, err_parity, err_frame, err_overrun;

    typedef struct {
        logic [DW:0] data;
        logic        perr;
        logic        ferr;
        logic        oerr;
        logic        do_read;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    uart_rx_core #(.DATA_W(DW)) i_uart_rx_core (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
        .par_mode(par_mode), .stop_mode(stop_mode), .wake_mode(wake_mode),
        .rd_buf(rd_buf), .rx_data(rx_data), .rx_full(rx_full), .rx_load(rx_load),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    initial begin
        os_tick = 1'b0;
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic expect_frame(input logic [DW:0] d, input logic pe, input logic fe,
                                input logic oe, input logic rd, input string req);
        exp_t e;
        e.data = d; e.perr = pe; e.ferr = fe; e.oerr = oe; e.do_read = rd; e.req = req;
        q.push_back(e);
    endtask

    // stop period driven tick by tick from pattern bits
    task automatic send_frame(input logic [DW:0] d, input int nb, input int pbit,
                              input int stop_len, input logic [63:0] stop_pat);
        rxd = 1'b0;
        wait_ticks(BIT_T);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            wait_ticks(BIT_T);
        end
        if (pbit >= 0) begin
            rxd = pbit[0];
            wait_ticks(BIT_T);
        end
        for (int t = 0; t < stop_len; t++) begin
            rxd = stop_pat[t];
            wait_ticks(1);
        end
        rxd = 1'b1;
        wait_ticks(BIT_T);
    endtask

    // monitor: pops expected items as the design loads the buffer
    initial begin
        rd_buf = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && rx_load) begin
                if (q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R10 unexpected load actual=%0h expected=none", rx_data);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.req, "data", 32'(rx_data), 32'(e.data));
                    chk(e.req, "err_parity R3", 32'(err_parity), 32'(e.perr));
                    chk(e.req, "err_frame R4", 32'(err_frame), 32'(e.ferr));
                    chk(e.req, "err_overrun R6", 32'(err_overrun), 32'(e.oerr));
                    chk(e.req, "full R5", 32'(rx_full), 32'd1);
                    if (e.do_read) begin
                        rd_buf = 1'b1;
                        @(negedge clk);
                        rd_buf = 1'b0;
                        chk("R7", "full after read", 32'(rx_full), 32'd0);
                        chk("R7", "flags after read",
                            32'({err_parity, err_frame, err_overrun}),
                            32'({e.perr, e.ferr, e.oerr}));
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        rst = 1'b1; rxd = 1'b1; rx_en = 1'b1;
        par_mode = 2'b00; stop_mode = 2'b00; wake_mode = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5", "reset full", 32'(rx_full), 0);
        chk("R5", "reset load", 32'(rx_load), 0);
        chk("R5", "reset flags", 32'({err_parity, err_frame, err_overrun}), 0);
        chk("R5", "reset data", 32'(rx_data), 0);
        wait_ticks(4);

        // R2: plain 8-bit frames
        expect_frame(9'h0A5, 0, 0, 0, 1, "R2");
        send_frame(9'h0A5, 8, -1, 16, 64'hFFFF);
        expect_frame(9'h03C, 0, 0, 0, 1, "R2");
        send_frame(9'h03C, 8, -1, 16, 64'hFFFF);

        // R3: 0x5B has five ones
        par_mode = 2'b01;
        expect_frame(9'h05B, 0, 0, 0, 1, "R3");
        send_frame(9'h05B, 8, 1, 16, 64'hFFFF);
        par_mode = 2'b10;
        expect_frame(9'h05B, 1, 0, 0, 1, "R3");
        send_frame(9'h05B, 8, 1, 16, 64'hFFFF);
        expect_frame(9'h0C3, 0, 0, 0, 1, "R3");
        send_frame(9'h0C3, 8, 1, 16, 64'hFFFF);
        par_mode = 2'b00;

        // R4 and R10: low stop, line stays low past the end
        expect_frame(9'h081, 0, 1, 0, 1, "R4 R10");
        send_frame(9'h081, 8, -1, 48, 64'h0);

        // R4: two stop bits, second one low
        stop_mode = 2'b10;
        expect_frame(9'h0F0, 0, 1, 0, 1, "R4");
        send_frame(9'h0F0, 8, -1, 32, 64'h0000_FFFF);
        expect_frame(9'h00F, 0, 0, 0, 1, "R4");
        send_frame(9'h00F, 8, -1, 32, 64'hFFFF_FFFF);

        // R4: one and a half, high at samples 7-9, low at 15-17
        stop_mode = 2'b01;
        expect_frame(9'h066, 0, 1, 0, 1, "R4");
        send_frame(9'h066, 8, -1, 24, 64'h0FFF);
        expect_frame(9'h099, 0, 0, 0, 1, "R4");
        send_frame(9'h099, 8, -1, 24, 64'hFF_FFFF);
        stop_mode = 2'b00;

        // R6: second frame overwrites unread first
        expect_frame(9'h011, 0, 0, 0, 0, "R6");
        send_frame(9'h011, 8, -1, 16, 64'hFFFF);
        expect_frame(9'h022, 0, 0, 1, 1, "R6");
        send_frame(9'h022, 8, -1, 16, 64'hFFFF);
        expect_frame(9'h033, 0, 0, 0, 1, "R6");
        send_frame(9'h033, 8, -1, 16, 64'hFFFF);

        // R8: address frame accepted, data frame dropped
        wake_mode = 1'b1;
        expect_frame(9'h1C4, 0, 0, 0, 1, "R8");
        send_frame(9'h1C4, 9, -1, 16, 64'hFFFF);
        send_frame(9'h055, 9, -1, 16, 64'hFFFF);
        chk("R8", "data kept after drop", 32'(rx_data), 32'h1C4);
        chk("R8", "full after drop", 32'(rx_full), 0);
        wake_mode = 1'b0;

        // R1: short low pulse is not a start bit
        rxd = 1'b0;
        wait_ticks(3);
        rxd = 1'b1;
        wait_ticks(40);
        chk("R1", "full after glitch", 32'(rx_full), 0);
        chk("R1", "data after glitch", 32'(rx_data), 32'h1C4);
        expect_frame(9'h096, 0, 0, 0, 1, "R1");
        send_frame(9'h096, 8, -1, 16, 64'hFFFF);

        // R9: disable partway through a frame
        expect_frame(9'h06E, 0, 0, 0, 1, "R9");
        fork
            send_frame(9'h06E, 8, -1, 16, 64'hFFFF);
            begin
                wait_ticks(BIT_T * 4);
                rx_en = 1'b0;
            end
        join
        send_frame(9'h077, 8, -1, 16, 64'hFFFF);
        chk("R9", "full while disabled", 32'(rx_full), 0);
        chk("R9", "data while disabled", 32'(rx_data), 32'h06E);
        rx_en = 1'b1;

        wait_ticks(32);
        chk("R5", "pending expected frames", 32'(q.size()), 0);
        summary();
    end

endmodule